// File: doc/BRIEF.md
# Bidirectional Port with Capture-Compare Lines

This block is a 16-line general-purpose I/O port. Each line can also act as a capture input or a compare output for a capture/compare timer unit that sits outside the block. Three bus-visible registers control the lines:

- an output latch,
- a direction mask,
- an open-drain mask.

Each line drives a tristate pad model, given as an output value and an output enable. It reads the pad back through a two-flop synchronizer. The synchronized value goes to the timer unit as the line's capture signal.

The timer unit changes a line's output latch without software. Per line it supplies a compare-trigger strobe, a two-bit compare mode and a timer-overflow flag:

- In toggle mode the trigger inverts the latch.
- In set/clear mode the trigger sets the latch on a match and clears it on an overflow.

A line set as an output drives its own pad. Its capture signal therefore follows the latch, so software can raise a capture event by writing the data register.

Top module: `ccport_gpio`

## Requirements
- R1: After synchronous reset the output latch, direction and open-drain registers all read 0x0000, and every pad_oe bit is 0.
- R2: A line whose direction bit is 0 has pad_oe low. A line whose direction bit is 1 and open-drain bit is 0 has pad_oe high, and pad_out equals its latch bit.
- R3: A line with direction 1 and open-drain 1 enables its driver only while its latch is 0 (driving low). It releases the pad (pad_oe low) while its latch is 1.
- R4: Each capture bit equals the pad_in bit as it stood before the second rising edge. For a line set as an output, the pad carries the latch, so a software write shows on capture two edges after the write edge.
- R5: Bus address 0 reads the latch for output lines and the synchronized pin for input lines. Address 1 reads direction, address 2 reads open-drain and address 3 reads zero. A write with bus_wr high takes effect at the next rising edge.
- R6: Compare mode 2'b01 (toggle): a trigger strobe inverts the line's latch at the next edge, whatever the overflow flag is.
- R7: Compare mode 2'b11 (set/clear): a trigger strobe with overflow 0 writes 1 to the latch, and with overflow 1 writes 0.
- R8: Compare modes 2'b00 and 2'b10 ignore trigger strobes: the latch keeps its value.
- R9: When a trigger update and a bus write to the data register hit the same line in one cycle, the trigger update wins. Other lines still take the written bits.
- R10: Without a trigger strobe, the overflow flag alone does not change the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 2 | Register select: 0 data, 1 direction, 2 open-drain, 3 unused |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data of the selected register |
| pad_in | input | 16 | Pin level seen at each pad |
| pad_out | output | 16 | Value driven to each pad |
| pad_oe | output | 16 | Pad driver enable per line |
| cmp_trig | input | 16 | Compare-trigger strobe per line |
| cmp_mode | input | 32 | Two-bit compare mode per line; line i uses bits 2i+1:2i |
| tmr_ovf | input | 16 | Timer-overflow flag per line, used with the trigger |
| capture | output | 16 | Synchronized pin state per line, sent to the timer unit |

## Verification
Latch updates from the bus or from a trigger are due after the one rising edge that samples them. pad_out, pad_oe and bus_rdata follow combinationally, so the bench drives inputs one nanosecond after an edge and checks them one nanosecond after the next. Capture and the input-side read data lag pad_in by exactly two edges. The bench checks that a changed pin has not yet reached capture after one edge and has arrived after the second. The pad is modelled in the bench as driver-when-enabled, otherwise an external level. This lets the software-triggered capture follow a latch write through the pin and the synchronizer.

// File: rtl/ccport_pkg.sv
package ccport_pkg;

    typedef enum logic [1:0] {
        CMP_OFF    = 2'b00,
        CMP_TOGGLE = 2'b01,
        CMP_RSVD   = 2'b10,
        CMP_SETCLR = 2'b11
    } cmp_mode_e;

    typedef enum logic [1:0] {
        SEL_DATA  = 2'd0,
        SEL_DIR   = 2'd1,
        SEL_ODRN  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     trig;
        logic     ovf;
        cmp_mode_e mode;
    } cmp_req_t;

    // Next latch value: compare hardware has priority over a software write.
    function automatic logic latch_next(input logic cur, input cmp_req_t req,
                                        input logic sw_we, input logic sw_bit);
        if (req.trig && req.mode == CMP_TOGGLE) return ~cur;
        if (req.trig && req.mode == CMP_SETCLR) return ~req.ovf;
        if (sw_we) return sw_bit;
        return cur;
    endfunction

    // Pad driver enable for one line.
    function automatic logic drive_en(input logic dir, input logic odrn, input logic lat);
        return dir & (~odrn | ~lat);
    endfunction

endpackage

// File: rtl/ccport_sync.sv
module ccport_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_sync
);
    localparam int CW = $clog2(STAGES + 1);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else if (s == 0) stage_q[s] <= d_in;
                else stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
            end
        end
    endgenerate

    assign d_sync = stage_q[STAGES-1];

    // checker state: cycles since reset, saturating at STAGES
    logic [CW-1:0] warm_q;
    always_ff @(posedge clk) begin
        if (rst) warm_q <= '0;
        else if (warm_q != CW'(STAGES)) warm_q <= warm_q + 1'b1;
    end

    // R4
    sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (warm_q == CW'(STAGES)) |-> (d_sync == $past(d_in, 2)));
endmodule

// File: rtl/ccport_line.sv
module ccport_line
    import ccport_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sw_we,
    input  logic     sw_bit,
    input  cmp_req_t req,
    output logic     latch_q
);
    always_ff @(posedge clk) begin
        if (rst) latch_q <= 1'b0;
        else     latch_q <= latch_next(latch_q, req, sw_we, sw_bit);
    end

    // R1
    line_reset_chk: assert property (@(posedge clk) rst |=> !latch_q);

    // R6
    toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (req.trig && req.mode == CMP_TOGGLE) |=> (latch_q == !$past(latch_q)));

    // R7 (holds with or without a same-cycle bus write, see R9)
    setclr_chk: assert property (@(posedge clk) disable iff (rst)
        (req.trig && req.mode == CMP_SETCLR) |=> (latch_q == !$past(req.ovf)));

    // R8
    ignored_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (req.trig && (req.mode == CMP_OFF || req.mode == CMP_RSVD) && !sw_we)
        |=> $stable(latch_q));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!req.trig && !sw_we) |=> $stable(latch_q));
endmodule

// File: rtl/ccport_regs.sv
module ccport_regs
    import ccport_pkg::*;
#(
    parameter int NUM_LINES = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  reg_sel_e             sel,
    input  logic                 wr,
    input  logic [NUM_LINES-1:0] wdata,
    input  logic [NUM_LINES-1:0] data_view,
    output logic [NUM_LINES-1:0] dir_q,
    output logic [NUM_LINES-1:0] odrn_q,
    output logic [NUM_LINES-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '0;
            odrn_q <= '0;
        end else if (wr) begin
            if (sel == SEL_DIR)  dir_q  <= wdata;
            if (sel == SEL_ODRN) odrn_q <= wdata;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_DATA: rdata = data_view;
            SEL_DIR:  rdata = dir_q;
            SEL_ODRN: rdata = odrn_q;
            default:  rdata = '0;
        endcase
    end

    // R1
    regs_reset_chk: assert property (@(posedge clk)
        rst |=> (dir_q == '0 && odrn_q == '0));

    // R5
    dir_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_DIR) |=> (dir_q == $past(wdata)));
endmodule

// File: rtl/ccport_gpio.sv
module ccport_gpio
    import ccport_pkg::*;
#(
    parameter int NUM_LINES   = 16,
    parameter int SYNC_STAGES = 2,
    localparam int MODE_W     = 2 * NUM_LINES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           bus_addr,
    input  logic                 bus_wr,
    input  logic [NUM_LINES-1:0] bus_wdata,
    output logic [NUM_LINES-1:0] bus_rdata,
    input  logic [NUM_LINES-1:0] pad_in,
    output logic [NUM_LINES-1:0] pad_out,
    output logic [NUM_LINES-1:0] pad_oe,
    input  logic [NUM_LINES-1:0] cmp_trig,
    input  logic [MODE_W-1:0]    cmp_mode,
    input  logic [NUM_LINES-1:0] tmr_ovf,
    output logic [NUM_LINES-1:0] capture
);
    reg_sel_e              sel;
    logic [NUM_LINES-1:0]  latch_v, dir_v, odrn_v, pin_sync, data_view;
    logic                  data_we;

    assign sel     = reg_sel_e'(bus_addr);
    assign data_we = bus_wr && (sel == SEL_DATA);

    ccport_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d_in(pad_in), .d_sync(pin_sync)
    );

    generate
        for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
            cmp_req_t req;
            assign req.trig = cmp_trig[i];
            assign req.ovf  = tmr_ovf[i];
            assign req.mode = cmp_mode_e'(cmp_mode[2*i +: 2]);

            ccport_line u_line (
                .clk(clk), .rst(rst), .sw_we(data_we), .sw_bit(bus_wdata[i]),
                .req(req), .latch_q(latch_v[i])
            );

            assign pad_out[i]   = latch_v[i];
            assign pad_oe[i]    = drive_en(dir_v[i], odrn_v[i], latch_v[i]);
            assign data_view[i] = dir_v[i] ? latch_v[i] : pin_sync[i];
        end
    endgenerate

    ccport_regs #(.NUM_LINES(NUM_LINES)) u_regs (
        .clk(clk), .rst(rst), .sel(sel), .wr(bus_wr), .wdata(bus_wdata),
        .data_view(data_view), .dir_q(dir_v), .odrn_q(odrn_v), .rdata(bus_rdata)
    );

    assign capture = pin_sync;

    // R2
    input_hiz_chk: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & ~dir_v) == '0);

    // R3
    odrain_release_chk: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & odrn_v & pad_out) == '0);

    // R9
    sw_write_chk: assert property (@(posedge clk) disable iff (rst)
        (data_we && cmp_trig == '0) |=> (latch_v == $past(bus_wdata)));
endmodule

// File: tb/ccport_gpio_tb_top.sv
module ccport_gpio_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata, pad_out, pad_oe, capture, pad_in;
    logic [15:0] ext = '0;
    logic [15:0] cmp_trig = '0, tmr_ovf = '0;
    logic [31:0] cmp_mode = '0;
    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    // pad: driven level when enabled, else external level
    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

    ccport_gpio dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .cmp_trig(cmp_trig),
        .cmp_mode(cmp_mode), .tmr_ovf(tmr_ovf), .capture(capture)
    );

    // {init[5], mode[4:3], ovf[2], trig[1], expected[0]} applied to line 5
    localparam logic [5:0] VEC [9] = '{
        6'b0_01_0_1_1, 6'b1_01_1_1_0, 6'b1_11_0_1_1, 6'b0_11_0_1_1,
        6'b1_11_1_1_0, 6'b0_11_0_0_0, 6'b1_11_1_0_1, 6'b1_00_0_1_1,
        6'b0_10_1_1_0
    };

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input logic [15:0] exp);
        bus_addr = a; #0.5;
        chk(tag, bus_rdata, exp);
    endtask

    initial begin
        #100000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        // R1 reset state
        rd_chk("R1 data", 2'd0, 16'h0000);
        rd_chk("R1 dir", 2'd1, 16'h0000);
        rd_chk("R1 odrn", 2'd2, 16'h0000);
        chk("R1 pad_oe", pad_oe, 16'h0000);

        // R2 direction and push-pull
        wr_reg(2'd1, 16'h00F0);
        wr_reg(2'd0, 16'h00A5);
        chk("R2 pad_oe", pad_oe, 16'h00F0);
        chk("R2 pad_out", pad_out & 16'h00F0, 16'h00A0);

        // R3 open-drain: lines 4..7, latch bits 5,7 set -> released
        wr_reg(2'd2, 16'h00F0);
        chk("R3 pad_oe", pad_oe, 16'h0050);
        rd_chk("R5 odrn read", 2'd2, 16'h00F0);
        rd_chk("R5 dir read", 2'd1, 16'h00F0);
        rd_chk("R5 unused addr", 2'd3, 16'h0000);
        wr_reg(2'd2, 16'h0000);

        // R5 mixed read: outputs from latch, inputs from synchronized pin
        ext = 16'h1234;
        tick(); tick();
        rd_chk("R5 data mixed", 2'd0, (16'h00A5 & 16'h00F0) | (16'h1234 & ~16'h00F0));

        // R4 capture delay on input line 0
        wr_reg(2'd1, 16'h0000);
        ext = 16'h0000;
        tick(); tick();
        ext[0] = 1'b1;
        tick();
        chk("R4 capture after 1 edge", capture & 16'h0001, 16'h0000);
        tick();
        chk("R4 capture after 2 edges", capture & 16'h0001, 16'h0001);

        // R4 software-triggered capture on output line 3
        ext = 16'h0000;
        wr_reg(2'd0, 16'h0000);
        wr_reg(2'd1, 16'h0008);
        tick(); tick();
        wr_reg(2'd0, 16'h0008);
        chk("R4 sw capture at write edge", capture & 16'h0008, 16'h0000);
        tick();
        chk("R4 sw capture +1 edge", capture & 16'h0008, 16'h0000);
        tick();
        chk("R4 sw capture +2 edges", capture & 16'h0008, 16'h0008);

        // R6 R7 R8 R10 vector table on line 5
        wr_reg(2'd1, 16'hFFFF);
        foreach (VEC[k]) begin
            string tag;
            logic [5:0] v;
            v = VEC[k];
            if (!v[1])                tag = "R10 ovf without trig";
            else if (v[4:3] == 2'b01) tag = "R6 toggle";
            else if (v[4:3] == 2'b11) tag = "R7 set/clear";
            else                      tag = "R8 ignored mode";
            wr_reg(2'd0, {10'd0, v[5], 5'd0});
            cmp_mode[11:10] = v[4:3];
            tmr_ovf[5] = v[2];
            cmp_trig[5] = v[1];
            tick();
            cmp_trig = '0; tmr_ovf = '0;
            rd_chk(tag, 2'd0, {10'd0, v[0], 5'd0});
            chk({tag, " pad_out"}, pad_out & 16'h0020, {10'd0, v[0], 5'd0});
        end

        // R9 collision: trigger on line 5 sets it while bus writes 0 there, 1 on line 6
        wr_reg(2'd0, 16'h0000);
        cmp_mode[11:10] = 2'b11;
        tmr_ovf[5] = 1'b0;
        cmp_trig[5] = 1'b1;
        wr_reg(2'd0, 16'h0040);
        cmp_trig = '0;
        rd_chk("R9 compare wins", 2'd0, 16'h0060);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule